// File: doc/BRIEF.md
# Two-Group Key Matrix Input Register

This block is an 8-bit key input register that a CPU reaches at one I/O address. Eight key inputs are split into two groups of four: a direction group (Right, Left, Up, Down) and an action group (A, B, Select, Start).

Software writes two select bits to say which group it wants to read. A later read returns three things. The two upper bits are fixed. The next two bits echo the last written select bits. The low nibble shows the key states of the chosen group, active low.

The CPU port is a plain register port, with no stream traffic and therefore no back-pressure:
- A write is taken on the clock edge where the write strobe is high and the address matches.
- Read data is combinational. It is valid in the cycle the read strobe is high.

Top module: `joy_matrix_reg`

## Requirements
- R1: Only address 0xFF00 (parameter `REG_ADDR`) is decoded. A write to any other address leaves the select bits unchanged. A read of any other address returns 0x00.
- R2: A read of the register always returns bits 7 and 6 as 1.
- R3: Bits 5 and 4 of a read return the values last written to data bits 5 and 4.
- R4: A write stores only data bits 5 and 4. Data written to bits 7, 6 and 3..0 has no effect on any later read.
- R5: After reset both select bits are 1, so a read returns 0xFF whatever keys are pressed.
- R6: When bit 4 is 0, the direction group drives the low nibble: bit 3 = not Down, bit 2 = not Up, bit 1 = not Left, bit 0 = not Right.
- R7: When bit 5 is 0 and bit 4 is 1, the action group drives the low nibble: bit 3 = not Start, bit 2 = not Select, bit 1 = not B, bit 0 = not A.
- R8: When bits 5 and 4 are both 0, the direction group wins and the action keys do not appear.
- R9: When bits 5 and 4 are both 1, the low nibble reads 0xF whatever the key states.
- R10: A new select value takes effect on the cycle after the write edge. A read in the same cycle as the write returns the old selection.
- R11: While the read strobe is low, the read data is 0x00.
- R12: Key changes reach the read data in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | CPU address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| key_right | input | 1 | Right pressed (high) |
| key_left | input | 1 | Left pressed |
| key_up | input | 1 | Up pressed |
| key_down | input | 1 | Down pressed |
| key_a | input | 1 | A pressed |
| key_b | input | 1 | B pressed |
| key_select | input | 1 | Select pressed |
| key_start | input | 1 | Start pressed |

## Verification
The bench targets five corner cases:
- **Both groups selected.** A design without direction priority would merge the action keys in or show them instead.
- **Neither group selected.** A leaky mux would show pressed keys.
- **Writes that fill the low nibble and the top bits with zeros.** A design storing the whole byte would read them back.
- **A write at a neighbouring address.** A loose decoder would change the selection.
- **A read in the same cycle as a write.** A design that bypasses the write data would expose the new selection one cycle too early.

Random key patterns and select values are then mixed across all four selections.

// File: rtl/joy_pkg.sv
package joy_pkg;
  localparam int DATA_W  = 8;
  localparam int NIB_W   = 4;
  localparam int SEL_W   = 2;
  localparam int SEL_LSB = 4;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [SEL_W-1:0] sel_t;

  // sel bit 0 (register bit 4) low picks direction, sel bit 1 (bit 5) low picks action
  localparam sel_t SEL_NONE = 2'b11;
endpackage

// File: rtl/joy_sel_reg.sv
module joy_sel_reg
  import joy_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  sel_t wr_sel,
  output sel_t sel_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= SEL_NONE;
    else if (wr_hit) sel_q <= wr_sel;
  end

  a_r3_sel_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> sel_q == $past(wr_sel));
  a_r1_sel_holds_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(sel_q));
endmodule

// File: rtl/joy_group_mux.sv
module joy_group_mux
  import joy_pkg::*;
(
  input  sel_t sel,
  input  nib_t dir_keys,
  input  nib_t act_keys,
  output nib_t nib_n
);
  always_comb begin
    if (!sel[0])      nib_n = ~dir_keys;
    else if (!sel[1]) nib_n = ~act_keys;
    else              nib_n = '1;
  end
endmodule

// File: rtl/joy_matrix_reg.sv
module joy_matrix_reg
  import joy_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFF00
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              key_right,
  input  logic              key_left,
  input  logic              key_up,
  input  logic              key_down,
  input  logic              key_a,
  input  logic              key_b,
  input  logic              key_select,
  input  logic              key_start
);
  localparam int TOP_W = DATA_W - SEL_LSB - SEL_W;

  logic hit, rd_hit, wr_hit;
  sel_t sel_q;
  nib_t dir_keys, act_keys, nib_n;
  logic unused_wdata_bits;

  assign hit    = (bus_addr == REG_ADDR);
  assign rd_hit = bus_rd & hit;
  assign wr_hit = bus_wr & hit;
  assign unused_wdata_bits = ^{bus_wdata[DATA_W-1:SEL_LSB+SEL_W], bus_wdata[SEL_LSB-1:0]};

  assign dir_keys = {key_down, key_up, key_left, key_right};
  assign act_keys = {key_start, key_select, key_b, key_a};

  joy_sel_reg u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_hit),
    .wr_sel (bus_wdata[SEL_LSB +: SEL_W]),
    .sel_q  (sel_q)
  );

  joy_group_mux u_mux (
    .sel      (sel_q),
    .dir_keys (dir_keys),
    .act_keys (act_keys),
    .nib_n    (nib_n)
  );

  assign bus_rdata = rd_hit ? {{TOP_W{1'b1}}, sel_q, nib_n} : '0;

  a_r2_top_ones: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> bus_rdata[DATA_W-1 -: TOP_W] == {TOP_W{1'b1}});
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);
  a_r9_none_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && bus_rdata[5:4] == 2'b11) |-> bus_rdata[3:0] == 4'hF);
  a_r8_dir_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !bus_rdata[4]) |-> bus_rdata[3:0] == ~dir_keys);
  a_r7_action_view: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && bus_rdata[5:4] == 2'b01) |-> bus_rdata[3:0] == ~act_keys);
  a_r10_write_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit ##1 rd_hit) |-> bus_rdata[5:4] == $past(bus_wdata[5:4]));
endmodule

// File: tb/sim_joy_matrix_reg.sv
module sim_joy_matrix_reg;
  logic clk = 0, rst_n = 0;
  logic [15:0] bus_addr = 16'h0000;
  logic bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  // keys = {down, up, left, right, start, select, b, a}
  logic [7:0] keys = 8'h00;
  logic [1:0] m_sel = 2'b11;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  joy_matrix_reg u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .key_right(keys[4]), .key_left(keys[5]), .key_up(keys[6]), .key_down(keys[7]),
    .key_a(keys[0]), .key_b(keys[1]), .key_select(keys[2]), .key_start(keys[3])
  );

  function automatic logic [7:0] exp_read(logic [15:0] a, logic rd, logic [1:0] s, logic [7:0] k);
    logic [3:0] low;
    if (!rd || a != 16'hFF00) return 8'h00;
    if (!s[0])      low = ~k[7:4];
    else if (!s[1]) low = ~k[3:0];
    else            low = 4'hF;
    return {2'b11, s, low};
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic do_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    if (a == 16'hFF00) m_sel = d[5:4];
  endtask

  task automatic do_read(string req, logic [15:0] a, logic [7:0] k);
    @(negedge clk);
    keys = k; bus_addr = a; bus_rd = 1;
    #1 chk(req, bus_rdata, exp_read(a, 1'b1, m_sel, k));
    bus_rd = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R5 reset state
    do_read("R5", 16'hFF00, 8'hFF);
    // R11 idle strobe
    @(negedge clk); keys = 8'h55; #1 chk("R11", bus_rdata, 8'h00);
    // R6 direction
    do_write(16'hFF00, 8'h20);
    do_read("R6", 16'hFF00, 8'h90);
    do_read("R6", 16'hFF00, 8'h60);
    // R12 live key change in same cycle
    @(negedge clk); bus_addr = 16'hFF00; bus_rd = 1; keys = 8'h10;
    #1 chk("R12", bus_rdata, 8'hEE);
    keys = 8'h80; #1 chk("R12", bus_rdata, 8'hE7);
    bus_rd = 0;
    // R7 action
    do_write(16'hFF00, 8'h10);
    do_read("R7", 16'hFF00, 8'h0A);
    do_read("R7", 16'hFF00, 8'hF5);
    // R8 both selected
    do_write(16'hFF00, 8'h00);
    do_read("R8", 16'hFF00, 8'h0F);
    do_read("R8", 16'hFF00, 8'h2C);
    // R9 neither, with low nibble written zero: R4
    do_write(16'hFF00, 8'h30);
    do_read("R9", 16'hFF00, 8'hFF);
    do_write(16'hFF00, 8'h10);
    do_read("R4", 16'hFF00, 8'h00);
    do_write(16'hFF00, 8'hCF);  // top/low ones, sel 00
    do_read("R4", 16'hFF00, 8'h00);
    // R1 neighbour address write/read
    do_write(16'hFF01, 8'h30);
    do_read("R1", 16'hFF00, 8'hA5);
    do_read("R1", 16'hFF01, 8'hA5);
    do_read("R1", 16'h7F00, 8'hA5);
    // R10 read in the write cycle shows old selection
    @(negedge clk);
    keys = 8'h3C; bus_addr = 16'hFF00; bus_wdata = 8'h10; bus_wr = 1; bus_rd = 1;
    #1 chk("R10", bus_rdata, exp_read(16'hFF00, 1'b1, m_sel, 8'h3C));
    @(negedge clk);
    bus_wr = 0; m_sel = 2'b01;
    #1 chk("R10", bus_rdata, exp_read(16'hFF00, 1'b1, m_sel, 8'h3C));
    bus_rd = 0;
    // random mix: R2 R3 across all selections
    for (int i = 0; i < 400; i++) begin
      logic [7:0] d, k;
      d = 8'($urandom);
      k = 8'($urandom);
      if ($urandom_range(0, 3) == 0) do_write(16'hFF00 ^ 16'($urandom_range(0, 1)), d);
      else do_read("R3", ($urandom_range(0, 7) == 0) ? 16'hFF04 : 16'hFF00, k);
    end
    // final R2 sanity
    do_read("R2", 16'hFF00, 8'h00);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule